// File: doc/BRIEF.md
# Port Change-Interrupt Controller

This block watches a parallel port and raises one interrupt when a watched pin changes. Each pin has its own choice of reference. It can be compared with the level it had on the previous clock, or with a fixed expected level. Only pins set as inputs and enabled for watching take part. On the first mismatch the block copies the port value into a capture register. It also sets a flag bit for every pin that caused the mismatch. It then holds both registers until software acknowledges the interrupt.

Software acknowledges the interrupt by finishing a read of either the port register or the capture register. A configuration bit picks which of the two counts. The register-access logic issues a one-cycle completion strobe once the last data bit of that read has left the serial shifter. If the mismatch is still present when the strobe arrives, the interrupt does not drop. The block takes a new snapshot of the port in the same cycle. The interrupt output can be push-pull active-low, push-pull active-high, or open-drain. The block also produces the port register value as software sees it, with per-bit input inversion applied.

Top module: `ioc_ctrl`

## Requirements
- R1: After reset, `flag_reg` and `cap_reg` are 00h and the interrupt is inactive. With `od_mode`=0 and `act_high`=0 this means `irq_level`=1 and `irq_oe`=1.
- R2: `port_val` equals `pin_sync` XOR `in_pol`. A set `in_pol` bit reports the inverted pin level.
- R3: A pin with `cmp_sel` bit 0 mismatches on a clock where its level differs from its level on the previous clock. On the first mismatch, at the next edge `flag_reg` gets a 1 for every mismatching pin, `cap_reg` gets that cycle's `port_val`, and the interrupt becomes active.
- R4: A pin with `cmp_sel` bit 1 mismatches whenever its level differs from its `cmp_val` bit. The mismatch is recorded in the same way as in R3.
- R5: While the interrupt is active and no accepted clear arrives, `flag_reg` and `cap_reg` do not change, even when more mismatches occur.
- R6: A completion strobe for the selected register clears the interrupt at the next edge when no mismatch is present. The selected register is capture when `clr_sel`=1 and port when `clr_sel`=0. The clear sets `flag_reg` to 00h and leaves `cap_reg` unchanged.
- R7: A completion strobe for the register that `clr_sel` does not select has no effect on `flag_reg`, `cap_reg` or the interrupt.
- R8: A pin with its `dir_in` bit at 0 (output) or its `irq_en` bit at 0 never raises the interrupt or sets a flag.
- R9: A selected strobe that arrives while a mismatch is present leaves the interrupt active. At the next edge `flag_reg` gets the current mismatching pins and `cap_reg` gets the current `port_val`.
- R10: With `od_mode`=1, `irq_level` is 0 and `irq_oe` equals the active state, whatever `act_high` is. With `od_mode`=0, `irq_oe` is 1 and `irq_level` is the active state when `act_high`=1 and its inverse when `act_high`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_sync | input | WIDTH | Synchronised pin levels |
| dir_in | input | WIDTH | Direction per pin, 1 = input |
| irq_en | input | WIDTH | Change-interrupt enable per pin |
| cmp_val | input | WIDTH | Expected level for default-compare pins |
| cmp_sel | input | WIDTH | Reference per pin, 1 = `cmp_val`, 0 = previous level |
| in_pol | input | WIDTH | Input inversion per pin |
| clr_sel | input | 1 | Clearing read, 1 = capture register, 0 = port register |
| od_mode | input | 1 | Open-drain interrupt output |
| act_high | input | 1 | Push-pull polarity, 1 = active high |
| port_rd_done | input | 1 | Port register read finished (one cycle) |
| cap_rd_done | input | 1 | Capture register read finished (one cycle) |
| port_val | output | WIDTH | Port register value after inversion |
| flag_reg | output | WIDTH | Pins that caused the pending interrupt |
| cap_reg | output | WIDTH | Port snapshot taken at the interrupt |
| irq_level | output | 1 | Level driven on the interrupt pin |
| irq_oe | output | 1 | Interrupt pin driver enable |

## Verification
The hardest case to reach is a clear that the block must refuse. The selected read strobe has to land in a cycle where a mismatch still exists. That mismatch must also differ from the one first recorded, so that a fresh snapshot can be told apart from a held one. The stimulus produces this with a default-compare pin held away from its expected level. While the interrupt is pending, an unrelated pin changes, so the port value moves but the register contents do not. The capture strobe then has to produce the new snapshot. Releasing the mismatch first and then strobing shows the same strobe clearing normally.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
   typedef enum logic [1:0] {
      DRV_ACT_LOW  = 2'd0,
      DRV_ACT_HIGH = 2'd1,
      DRV_OPEN     = 2'd2
   } irq_style_e;

   function automatic irq_style_e pick_style(input logic od, input logic hi);
      if (od)      return DRV_OPEN;
      else if (hi) return DRV_ACT_HIGH;
      else         return DRV_ACT_LOW;
   endfunction
endpackage

// File: rtl/ioc_detect.sv
module ioc_detect #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_sync,
   input  logic [WIDTH-1:0] dir_in,
   input  logic [WIDTH-1:0] irq_en,
   input  logic [WIDTH-1:0] cmp_val,
   input  logic [WIDTH-1:0] cmp_sel,
   input  logic [WIDTH-1:0] in_pol,
   output logic [WIDTH-1:0] port_val,
   output logic [WIDTH-1:0] hit
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pin_sync;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic ref_lvl;
      logic watched;
      always_comb begin
         ref_lvl     = cmp_sel[i] ? cmp_val[i] : prev_q[i];
         watched     = dir_in[i] & irq_en[i];
         hit[i]      = watched & (pin_sync[i] ^ ref_lvl);
         port_val[i] = pin_sync[i] ^ in_pol[i];
      end
   end
endmodule

// File: rtl/ioc_capture.sv
module ioc_capture #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] hit,
   input  logic [WIDTH-1:0] port_val,
   input  logic             clr_sel,
   input  logic             port_rd_done,
   input  logic             cap_rd_done,
   output logic [WIDTH-1:0] flag_q,
   output logic [WIDTH-1:0] cap_q,
   output logic             pend_q
);
   logic clr_req;
   logic any_hit;
   logic take;

   always_comb begin
      clr_req = clr_sel ? cap_rd_done : port_rd_done;
      any_hit = |hit;
      take    = any_hit & (~pend_q | clr_req);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         flag_q <= '0;
         cap_q  <= '0;
      end else if (take) begin
         pend_q <= 1'b1;
         flag_q <= hit;
         cap_q  <= port_val;
      end else if (clr_req) begin
         pend_q <= 1'b0;
         flag_q <= '0;
      end
   end
endmodule

// File: rtl/ioc_pin_drive.sv
module ioc_pin_drive
   import ioc_pkg::*;
(
   input  logic pend,
   input  logic od_mode,
   input  logic act_high,
   output logic lvl,
   output logic oe
);
   irq_style_e style;

   always_comb begin
      style = pick_style(od_mode, act_high);
      unique case (style)
         DRV_OPEN:     begin lvl = 1'b0;  oe = pend; end
         DRV_ACT_HIGH: begin lvl = pend;  oe = 1'b1; end
         default:      begin lvl = ~pend; oe = 1'b1; end
      endcase
   end
endmodule

// File: rtl/ioc_ctrl.sv
module ioc_ctrl #(
   parameter int WIDTH   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_sync,
   input  logic [WIDTH-1:0] dir_in,
   input  logic [WIDTH-1:0] irq_en,
   input  logic [WIDTH-1:0] cmp_val,
   input  logic [WIDTH-1:0] cmp_sel,
   input  logic [WIDTH-1:0] in_pol,
   input  logic             clr_sel,
   input  logic             od_mode,
   input  logic             act_high,
   input  logic             port_rd_done,
   input  logic             cap_rd_done,
   output logic [WIDTH-1:0] port_val,
   output logic [WIDTH-1:0] flag_reg,
   output logic [WIDTH-1:0] cap_reg,
   output logic             irq_level,
   output logic             irq_oe
);
   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("ioc_ctrl: WIDTH must be 1..64");
   end

   logic [WIDTH-1:0] hit;
   logic             pend;
   logic             lvl_c;
   logic             oe_c;

   ioc_detect #(.WIDTH(WIDTH)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_sync (pin_sync),
      .dir_in   (dir_in),
      .irq_en   (irq_en),
      .cmp_val  (cmp_val),
      .cmp_sel  (cmp_sel),
      .in_pol   (in_pol),
      .port_val (port_val),
      .hit      (hit)
   );

   ioc_capture #(.WIDTH(WIDTH)) u_capture (
      .clk          (clk),
      .rst_n        (rst_n),
      .hit          (hit),
      .port_val     (port_val),
      .clr_sel      (clr_sel),
      .port_rd_done (port_rd_done),
      .cap_rd_done  (cap_rd_done),
      .flag_q       (flag_reg),
      .cap_q        (cap_reg),
      .pend_q       (pend)
   );

   ioc_pin_drive u_drive (
      .pend     (pend),
      .od_mode  (od_mode),
      .act_high (act_high),
      .lvl      (lvl_c),
      .oe       (oe_c)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_level <= 1'b1;
            irq_oe    <= 1'b1;
         end else begin
            irq_level <= lvl_c;
            irq_oe    <= oe_c;
         end
      end
   end else begin : g_out_comb
      always_comb begin
         irq_level = lvl_c;
         irq_oe    = oe_c;
      end
   end
endmodule

// File: rtl/ioc_ctrl_chk.sv
module ioc_ctrl_chk #(
   parameter int WIDTH   = 8,
   parameter bit OUT_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] dir_in,
   input logic [WIDTH-1:0] irq_en,
   input logic             clr_sel,
   input logic             od_mode,
   input logic             act_high,
   input logic             port_rd_done,
   input logic             cap_rd_done,
   input logic [WIDTH-1:0] flag_reg,
   input logic [WIDTH-1:0] cap_reg,
   input logic             irq_level,
   input logic             irq_oe
);
   logic active;
   logic sel_clr;
   assign active  = (flag_reg != '0);
   assign sel_clr = clr_sel ? cap_rd_done : port_rd_done;

   // R5: pending state frozen without a selected clear
   a_r5_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !sel_clr) |=> ($stable(flag_reg) && $stable(cap_reg)));

   // R8: fresh flags only on watched input pins
   a_r8_only_watched: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> ((flag_reg & ~($past(dir_in) & $past(irq_en))) == '0));

   // R7: strobe of the other register never drops the interrupt
   a_r7_other_read: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !sel_clr) |=> active);

   if (!OUT_REG) begin : g_pin_chk
      // R10: open-drain only pulls low
      a_r10_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
         od_mode |-> (!irq_level && (irq_oe == active)));
      // R10: push-pull always drives with selected polarity
      a_r10_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
         !od_mode |-> (irq_oe && (irq_level == (act_high ? active : !active))));
   end
endmodule

bind ioc_ctrl ioc_ctrl_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dir_in       (dir_in),
   .irq_en       (irq_en),
   .clr_sel      (clr_sel),
   .od_mode      (od_mode),
   .act_high     (act_high),
   .port_rd_done (port_rd_done),
   .cap_rd_done  (cap_rd_done),
   .flag_reg     (flag_reg),
   .cap_reg      (cap_reg),
   .irq_level    (irq_level),
   .irq_oe       (irq_oe)
);

// File: tb/tb_ioc_ctrl.sv
module tb_ioc_ctrl;
   localparam int CLK_PER = 10;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] pin_sync = '0, dir_in = '1, irq_en = '0;
   logic [W-1:0] cmp_val = '0, cmp_sel = '0, in_pol = '0;
   logic clr_sel = 1'b1, od_mode = 1'b0, act_high = 1'b0;
   logic port_rd_done = 1'b0, cap_rd_done = 1'b0;
   logic [W-1:0] port_val, flag_reg, cap_reg;
   logic irq_level, irq_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [W-1:0] fl;
      logic [W-1:0] cp;
      logic [W-1:0] pv;
      logic         lv;
      logic         oe;
      string        tag;
   } exp_t;
   exp_t q[$];

   always #(CLK_PER/2) clk = ~clk;

   ioc_ctrl #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .dir_in(dir_in),
      .irq_en(irq_en), .cmp_val(cmp_val), .cmp_sel(cmp_sel), .in_pol(in_pol),
      .clr_sel(clr_sel), .od_mode(od_mode), .act_high(act_high),
      .port_rd_done(port_rd_done), .cap_rd_done(cap_rd_done),
      .port_val(port_val), .flag_reg(flag_reg), .cap_reg(cap_reg),
      .irq_level(irq_level), .irq_oe(irq_oe)
   );

   // driver: one clock edge, then queue what must be visible after it
   task automatic cyc(input logic [W-1:0] fl, input logic [W-1:0] cp,
                      input logic [W-1:0] pv, input logic lv, input logic oe,
                      input string tag);
      exp_t e;
      @(posedge clk);
      e.fl = fl; e.cp = cp; e.pv = pv; e.lv = lv; e.oe = oe; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   // monitor: samples a quarter period after the edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PER/4);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (flag_reg !== e.fl || cap_reg !== e.cp || port_val !== e.pv ||
                irq_level !== e.lv || irq_oe !== e.oe) begin
               bad++;
               $display("FAIL %s: got flag=%h cap=%h port=%h lvl=%b oe=%b exp flag=%h cap=%h port=%h lvl=%b oe=%b",
                        e.tag, flag_reg, cap_reg, port_val, irq_level, irq_oe,
                        e.fl, e.cp, e.pv, e.lv, e.oe);
            end
         end
      end
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cyc(8'h00, 8'h00, 8'h00, 1, 1, "R1 reset state");
      pin_sync = 8'hA5; in_pol = 8'h0F;
      cyc(8'h00, 8'h00, 8'hAA, 1, 1, "R2 inversion");
      in_pol = 8'h00; irq_en = 8'h01;
      cyc(8'h00, 8'h00, 8'hA5, 1, 1, "R3 stable pins");
      pin_sync = 8'hA4;
      cyc(8'h01, 8'hA4, 8'hA4, 0, 1, "R3 previous-value event");
      pin_sync = 8'hA5;
      cyc(8'h01, 8'hA4, 8'hA5, 0, 1, "R5 event while pending");
      port_rd_done = 1'b1;
      cyc(8'h01, 8'hA4, 8'hA5, 0, 1, "R7 port read, capture selected");
      port_rd_done = 1'b0; cap_rd_done = 1'b1;
      cyc(8'h00, 8'hA4, 8'hA5, 1, 1, "R6 capture read clears");
      cap_rd_done = 1'b0;
      dir_in = 8'hFD; irq_en = 8'h03; pin_sync = 8'hA7;
      cyc(8'h00, 8'hA4, 8'hA7, 1, 1, "R8 output pin change");
      irq_en = 8'h04; cmp_sel = 8'h04; cmp_val = 8'h00;
      cyc(8'h04, 8'hA7, 8'hA7, 0, 1, "R4 default-compare event");
      pin_sync = 8'h27;
      cyc(8'h04, 8'hA7, 8'h27, 0, 1, "R5 port moves while pending");
      cap_rd_done = 1'b1;
      cyc(8'h04, 8'h27, 8'h27, 0, 1, "R9 refused clear, new snapshot");
      cap_rd_done = 1'b0; pin_sync = 8'h23;
      cyc(8'h04, 8'h27, 8'h23, 0, 1, "R9 still pending after match");
      clr_sel = 1'b0; cap_rd_done = 1'b1;
      cyc(8'h04, 8'h27, 8'h23, 0, 1, "R7 capture read, port selected");
      cap_rd_done = 1'b0; port_rd_done = 1'b1;
      cyc(8'h00, 8'h27, 8'h23, 1, 1, "R6 port read clears");
      port_rd_done = 1'b0; act_high = 1'b1;
      cyc(8'h00, 8'h27, 8'h23, 0, 1, "R10 active-high idle");
      pin_sync = 8'h27;
      cyc(8'h04, 8'h27, 8'h27, 1, 1, "R10 active-high asserted");
      od_mode = 1'b1;
      cyc(8'h04, 8'h27, 8'h27, 0, 1, "R10 open-drain pulling low");
      pin_sync = 8'h23;
      cyc(8'h04, 8'h27, 8'h23, 0, 1, "R10 open-drain hold");
      port_rd_done = 1'b1;
      cyc(8'h00, 8'h27, 8'h23, 0, 0, "R10 open-drain released");
      port_rd_done = 1'b0; od_mode = 1'b0; act_high = 1'b0;
      dir_in = 8'hFF; irq_en = 8'h03; cmp_sel = 8'h00; pin_sync = 8'h20;
      cyc(8'h03, 8'h20, 8'h20, 0, 1, "R3 two pins at once");
      in_pol = 8'hFF;
      cyc(8'h03, 8'h20, 8'hDF, 0, 1, "R2 R5 inversion while pending");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule